// File: doc/BRIEF.md
# LIN Slave Baud-Rate Synchronizer

This block watches the receive line of a LIN slave node. It recognises the long dominant break that opens a header and the recessive delimiter that follows it. It then times the 0x55 sync byte to find out how many sampling ticks one bit lasts, and it loads that result into a baud divider register. The register holds a 16-bit integer part and a 3-bit fractional part, which a separate fractional baud generator uses.

All line activity is evaluated only on cycles where the sampling-clock enable is high. The timing window opens at the falling edge of the sync start bit. It closes at the fourth falling edge after that one, which lies eight bit times later. The tick count in that window, divided by eight, gives the divider, and the three remainder bits give the fraction.

While the window is open, the block compares the length of every level run with the length of the start bit. A run that is too short or too long means the byte was not 0x55. In that case the block abandons the measurement and sets a sticky error flag. An interrupt request follows that flag through an enable mask, and only the reset-status strobe clears the flag.

Top module: `lin_sync_slave`

## Requirements
- R1: After reset, `div_out` equals INIT_DIV (default 4), `frac_out` equals INIT_FRAC (default 0), and `sync_err` and `irq` are 0.
- R2: A break is accepted when the line is seen at 0 on at least 13×`div_out` consecutive sample ticks and is then seen at 1. After a low run that is one tick shorter, the following sync field is not measured and `div_out`/`frac_out` stay unchanged.
- R3: Tick 0 is the sample tick on which the line is first seen at 0 after the delimiter. Measurement ends on the sample tick of the fourth 1→0 transition after tick 0. The count C is the number of ticks from tick 0 up to but not including that tick. On the clock edge of that tick, `div_out` becomes C[18:3] and `frac_out` becomes C[2:0]. For example, C = 0x0316D gives 0x062D and 3'b101.
- R4: Only cycles with `samp_en` = 1 are evaluated. Line values on other cycles have no effect on the result.
- R5: While `slave_en` is 0, no synchronization takes place and `div_out`/`frac_out` stay unchanged.
- R6: Let L be the start-bit run length and let d = floor(L/2). Every later run inside the window must last between d and L+d ticks inclusive. If one does not, the byte is taken as not 0x55. `sync_err` is then set on that tick, `div_out`/`frac_out` keep their values, and break detection restarts. The bytes 0x57, 0xD5 and 0x54 all trigger this.
- R7: `sync_err` stays set until a cycle with `clr_status` = 1 clears it. A new error in the same cycle wins. A later successful sync does not clear it.
- R8: `irq` is 1 exactly when `sync_err` is 1 and `irq_mask` is 1.
- R9: Suppose the 19-bit count would pass its maximum, 2^19−1, before the window closes. The measurement is then dropped without setting `sync_err`, the divider is kept, and a fresh break is needed before the next measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_in | input | 1 | Receive line, already synchronized to clk |
| samp_en | input | 1 | Sampling-clock enable; one sample tick per high cycle |
| slave_en | input | 1 | Enables synchronization (slave mode) |
| irq_mask | input | 1 | Interrupt enable for the sync error |
| clr_status | input | 1 | Reset-status strobe that clears the sync error |
| div_out | output | DIV_W (16) | Integer baud divider |
| frac_out | output | FRAC_W (3) | Fractional baud divider |
| sync_err | output | 1 | Sticky inconsistent-sync error |
| irq | output | 1 | Masked interrupt request |

## Verification
The sync field is applied with these bit times:
- an exact integer bit time, to check the divider path;
- a count with a non-zero remainder, to check the split into fraction bits;
- the large worked count, which is the only stimulus that uses the upper divider bits.

Break lengths one tick below and exactly at the threshold show that the comparison includes its bound. The bytes 0x57, 0xD5 and 0x54 fail the run checks in three different ways: a run that is too long, a last data bit that is high, and a start run that is too long so that later runs are too short. A frame with cycles where `samp_en` is low and the line is inverted tells a tick-gated design apart from one that samples every clock. A second, narrow instance forces a counter overflow and then shows that a sync field without a new break is ignored.

// File: rtl/lin_sync_pkg.sv
// Shared types of the LIN slave synchronizer.
// Assumes: nothing beyond the enum encoding being internal.
package lin_sync_pkg;
    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_DELIM = 2'd1,
        ST_MEAS  = 2'd2
    } sync_state_t;
endpackage

// File: rtl/lsync_break_det.sv
// Break detector: counts consecutive low sample ticks and reports a valid
// break when the line rises after at least BRK_BITS bit times of low.
// Assumes: bit_div holds the current ticks-per-bit estimate; the counter
// is cleared whenever the detector is not enabled.
module lsync_break_det #(
    parameter int DIV_W    = 16,
    parameter int BRK_BITS = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             enable,
    input  logic             rx,
    input  logic [DIV_W-1:0] bit_div,
    output logic             brk_ok
);
    localparam int LOW_W = DIV_W + $clog2(BRK_BITS + 1);

    logic [LOW_W-1:0] low_cnt;
    logic [LOW_W-1:0] brk_len;

    // Required low length in ticks for the current bit estimate.
    always_comb begin
        brk_len = LOW_W'(bit_div) * LOW_W'(BRK_BITS);
    end

    // Break accepted on the rising tick after a long enough low run.
    always_comb begin
        brk_ok = enable && tick && rx && (low_cnt != '0) && (low_cnt >= brk_len);
    end

    // Saturating low-run counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            low_cnt <= '0;
        end else if (tick) begin
            if (rx) begin
                low_cnt <= '0;
            end else if (low_cnt != {LOW_W{1'b1}}) begin
                low_cnt <= low_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/lsync_field_timer.sv
// Sync field timer: counts sample ticks from the start-bit edge to the
// fourth following falling edge, and checks each level run against the
// start-bit length to recognise a non-0x55 byte.
// Assumes: start is a single tick that opens the window; active is high
// on the ticks after that while the window stays open.
module lsync_field_timer #(
    parameter int CNT_W    = 19,
    parameter int END_FALL = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic             active,
    input  logic             rx,
    output logic [CNT_W-1:0] count,
    output logic             done,
    output logic             bad,
    output logic             ovf
);
    localparam int EW = CNT_W + 1;
    localparam int FW = $clog2(END_FALL + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] l0_q;
    logic             have_l0;
    logic [FW-1:0]    falls_q;
    logic             lvl_q;
    logic             edge_s;
    logic             fall_s;
    logic [EW-1:0]    lo_lim;
    logic [EW-1:0]    hi_lim;
    logic [EW-1:0]    run_x;

    assign count = cnt_q;

    // Edge decode and run-length limits derived from the start-bit run.
    always_comb begin
        edge_s = (rx != lvl_q);
        fall_s = lvl_q && !rx;
        lo_lim = {1'b0, l0_q} >> 1;
        hi_lim = {1'b0, l0_q} + ({1'b0, l0_q} >> 1);
        run_x  = {1'b0, run_q};
    end

    // Window outcome on the current tick: close, reject or overflow.
    always_comb begin
        done = active && tick && have_l0 && edge_s && fall_s &&
               (run_x >= lo_lim) && (falls_q == FW'(END_FALL - 1));
        bad  = active && tick && have_l0 &&
               ((edge_s && (run_x < lo_lim)) || (!edge_s && (run_x >= hi_lim)));
        ovf  = active && tick && !done && !bad && (&cnt_q);
    end

    // Window counters, run length and edge bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            run_q   <= '0;
            l0_q    <= '0;
            have_l0 <= 1'b0;
            falls_q <= '0;
            lvl_q   <= 1'b1;
        end else if (start) begin
            cnt_q   <= CNT_W'(1);
            run_q   <= CNT_W'(1);
            have_l0 <= 1'b0;
            falls_q <= '0;
            lvl_q   <= 1'b0;
        end else if (active && tick) begin
            lvl_q <= rx;
            cnt_q <= cnt_q + 1'b1;
            if (edge_s) begin
                run_q <= CNT_W'(1);
                if (!have_l0) begin
                    l0_q    <= run_q;
                    have_l0 <= 1'b1;
                end else if (fall_s) begin
                    falls_q <= falls_q + 1'b1;
                end
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/lsync_status.sv
// Sticky sync-error flag with a masked interrupt request.
// Assumes: set_err is a one-cycle event; a set wins over a clear.
module lsync_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set_err,
    input  logic clr,
    input  logic mask,
    output logic err,
    output logic irq
);
    // Interrupt follows the flag through its enable.
    always_comb begin
        irq = err && mask;
    end

    // Flag: set by an error, cleared only by the status strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err <= 1'b0;
        end else if (set_err) begin
            err <= 1'b1;
        end else if (clr) begin
            err <= 1'b0;
        end
    end
endmodule

// File: rtl/lin_sync_slave.sv
// LIN slave baud synchronizer top: break -> delimiter -> sync timing,
// then loads the measured integer/fraction divider.
// Assumes: rx_in is synchronous to clk; INIT_DIV is non-zero.
module lin_sync_slave
    import lin_sync_pkg::*;
#(
    parameter int                DIV_W     = 16,
    parameter int                FRAC_W    = 3,
    parameter int                BRK_BITS  = 13,
    parameter logic [DIV_W-1:0]  INIT_DIV  = DIV_W'(4),
    parameter logic [FRAC_W-1:0] INIT_FRAC = FRAC_W'(0)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_in,
    input  logic              samp_en,
    input  logic              slave_en,
    input  logic              irq_mask,
    input  logic              clr_status,
    output logic [DIV_W-1:0]  div_out,
    output logic [FRAC_W-1:0] frac_out,
    output logic              sync_err,
    output logic              irq
);
    localparam int CNT_W = DIV_W + FRAC_W;

    sync_state_t      state;
    logic             brk_ok;
    logic             meas_start;
    logic             meas_active;
    logic             meas_done;
    logic             meas_bad;
    logic             meas_ovf;
    logic [CNT_W-1:0] meas_cnt;

    // Phase qualifiers for the sub-blocks.
    always_comb begin
        meas_start  = slave_en && samp_en && (state == ST_DELIM) && !rx_in;
        meas_active = slave_en && (state == ST_MEAS);
    end

    lsync_break_det #(
        .DIV_W    (DIV_W),
        .BRK_BITS (BRK_BITS)
    ) u_brk (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (samp_en),
        .enable  (slave_en && (state == ST_HUNT)),
        .rx      (rx_in),
        .bit_div (div_out),
        .brk_ok  (brk_ok)
    );

    lsync_field_timer #(
        .CNT_W    (CNT_W),
        .END_FALL (4)
    ) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (samp_en),
        .start  (meas_start),
        .active (meas_active),
        .rx     (rx_in),
        .count  (meas_cnt),
        .done   (meas_done),
        .bad    (meas_bad),
        .ovf    (meas_ovf)
    );

    lsync_status u_sts (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_err (meas_bad),
        .clr     (clr_status),
        .mask    (irq_mask),
        .err     (sync_err),
        .irq     (irq)
    );

    // Header phase sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n || !slave_en) begin
            state <= ST_HUNT;
        end else if (samp_en) begin
            case (state)
                ST_HUNT:  if (brk_ok) state <= ST_DELIM;
                ST_DELIM: if (!rx_in) state <= ST_MEAS;
                ST_MEAS:  if (meas_done || meas_bad || meas_ovf) state <= ST_HUNT;
                default:  state <= ST_HUNT;
            endcase
        end
    end

    // Baud register: initial values until a successful measurement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_out  <= INIT_DIV;
            frac_out <= INIT_FRAC;
        end else if (meas_done) begin
            div_out  <= meas_cnt[CNT_W-1:FRAC_W];
            frac_out <= meas_cnt[FRAC_W-1:0];
        end
    end
endmodule

// File: rtl/lin_sync_slave_chk.sv
// Property checker for lin_sync_slave, attached by bind.
// Assumes: connected to the top's ports and its window outcome strobes.
module lin_sync_slave_chk #(
    parameter int DIV_W  = 16,
    parameter int FRAC_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              samp_en,
    input logic              irq_mask,
    input logic              clr_status,
    input logic [DIV_W-1:0]  div_out,
    input logic [FRAC_W-1:0] frac_out,
    input logic              sync_err,
    input logic              irq,
    input logic              meas_done,
    input logic              meas_bad,
    input logic              meas_ovf
);
    // R3: the baud register changes only on a closed window.
    a_r3_div_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        !meas_done |=> ($stable(div_out) && $stable(frac_out)));

    // R4: no window outcome on a cycle without a sample tick.
    a_r4_no_tick_no_event: assert property (@(posedge clk) disable iff (!rst_n)
        !samp_en |-> (!meas_done && !meas_bad && !meas_ovf));

    // R6: a rejected byte raises the error and keeps the divider.
    a_r6_bad_sets_err: assert property (@(posedge clk) disable iff (!rst_n)
        meas_bad |=> (sync_err && $stable(div_out) && $stable(frac_out)));

    // R7: the error is held until cleared.
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_err && !clr_status) |=> sync_err);

    // R7: a clear without a new error drops the flag.
    a_r7_err_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_status && !meas_bad) |=> !sync_err);

    // R8: a request only rises with the flag or its enable.
    a_r8_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($rose(sync_err) || $rose(irq_mask)));

    // R9: an overflow neither sets the error nor loads the divider.
    a_r9_ovf_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        meas_ovf |=> ($stable(div_out) && (sync_err == $past(sync_err && !clr_status))));
endmodule

bind lin_sync_slave lin_sync_slave_chk #(
    .DIV_W  (DIV_W),
    .FRAC_W (FRAC_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .samp_en    (samp_en),
    .irq_mask   (irq_mask),
    .clr_status (clr_status),
    .div_out    (div_out),
    .frac_out   (frac_out),
    .sync_err   (sync_err),
    .irq        (irq),
    .meas_done  (meas_done),
    .meas_bad   (meas_bad),
    .meas_ovf   (meas_ovf)
);

// File: tb/lin_sync_slave_tb.sv
module lin_sync_slave_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYC   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx = 1'b1;
    logic        samp = 1'b1;
    logic        slv = 1'b1;
    logic        mask = 1'b0;
    logic        clr = 1'b0;
    logic [15:0] div_o;
    logic [2:0]  frac_o;
    logic        err_o;
    logic        irq_o;
    logic [7:0]  s_div;
    logic [2:0]  s_frac;
    logic        s_err;
    logic        s_irq;

    int vecs = 0;
    int fails = 0;
    string cur_req = "R1";
    bit model_on = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lin_sync_slave u_dut (
        .clk(clk), .rst_n(rst_n), .rx_in(rx), .samp_en(samp), .slave_en(slv),
        .irq_mask(mask), .clr_status(clr), .div_out(div_o), .frac_out(frac_o),
        .sync_err(err_o), .irq(irq_o)
    );

    lin_sync_slave #(.DIV_W(8), .INIT_DIV(8'd4)) u_dut_ovf (
        .clk(clk), .rst_n(rst_n), .rx_in(rx), .samp_en(samp), .slave_en(slv),
        .irq_mask(mask), .clr_status(clr), .div_out(s_div), .frac_out(s_frac),
        .sync_err(s_err), .irq(s_irq)
    );

    // Behavioural reference: phase, low run, window bookkeeping.
    int m_ph = 0, m_low = 0, m_cnt = 0, m_run = 0, m_l0 = 0, m_falls = 0;
    bit m_have = 0, m_lvl = 1, m_err = 0;
    int m_div = 4, m_frac = 0;

    task automatic model_tick();
        bit seterr = 0;
        if (!slv) begin
            m_ph = 0; m_low = 0;
        end else if (samp) begin
            if (m_ph == 0) begin
                if (!rx) m_low++;
                else begin
                    if (m_low > 0 && m_low >= 13 * m_div) m_ph = 1;
                    m_low = 0;
                end
            end else if (m_ph == 1) begin
                if (!rx) begin
                    m_ph = 2; m_cnt = 1; m_run = 1; m_have = 0; m_falls = 0; m_lvl = 0;
                end
            end else begin
                bit e = (rx != m_lvl);
                bit f = m_lvl && !rx;
                int lo = m_l0 / 2;
                int hi = m_l0 + m_l0 / 2;
                if (m_have && ((e && m_run < lo) || (!e && m_run >= hi))) begin
                    seterr = 1; m_ph = 0; m_low = 0;
                end else if (m_have && f && m_falls == 3) begin
                    m_div = m_cnt / 8; m_frac = m_cnt % 8; m_ph = 0; m_low = 0;
                end else if (m_cnt == 524287) begin
                    m_ph = 0; m_low = 0;
                end else begin
                    if (e) begin
                        if (!m_have) begin m_l0 = m_run; m_have = 1; end
                        else if (f) m_falls++;
                        m_run = 1;
                    end else m_run++;
                    m_cnt++;
                    m_lvl = rx;
                end
            end
        end
        if (seterr) m_err = 1;
        else if (clr) m_err = 0;
    endtask

    task automatic compare();
        vecs++;
        if (div_o !== 16'(m_div) || frac_o !== 3'(m_frac) || err_o !== m_err ||
            irq_o !== (m_err && mask)) begin
            fails++;
            $display("FAIL %s: div=%h frac=%0d err=%0b irq=%0b expected div=%h frac=%0d err=%0b irq=%0b",
                     cur_req, div_o, frac_o, err_o, irq_o, 16'(m_div), m_frac, m_err, m_err && mask);
        end
    endtask

    task automatic check(string req, int act, int exp);
        vecs++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(logic r, logic s);
        rx = r; samp = s;
        @(posedge clk);
        if (model_on) model_tick();
        @(negedge clk);
        if (model_on) compare();
        clr = 1'b0;
    endtask

    task automatic send(logic lv, int n, bit gap);
        for (int i = 0; i < n; i++) begin
            if (gap) step(~lv, 1'b0);
            step(lv, 1'b1);
        end
    endtask

    // Break (optional), delimiter, then a byte framed with start/stop whose
    // bit boundaries are floor(k*c/8) ticks from the start edge.
    task automatic frame(int brk, int c, logic [7:0] b, bit gap);
        if (brk > 0) begin
            send(1'b0, brk, gap);
            send(1'b1, 3, gap);
        end
        for (int k = 0; k < 10; k++) begin
            int t0 = (k * c) / 8;
            int t1 = ((k + 1) * c) / 8;
            logic lv = (k == 0) ? 1'b0 : (k == 9) ? 1'b1 : b[k-1];
            if (k == 9) t1 = t0 + c / 8 + 4;
            send(lv, t1 - t0, gap);
        end
    endtask

    task automatic pulse_clr();
        clr = 1'b1;
        step(1'b1, 1'b1);
    endtask

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 div", div_o, 16'h0004);
        check("R1 frac", frac_o, 0);
        check("R1 err", err_o, 0);
        check("R1 irq", irq_o, 0);
        model_on = 1'b1;

        cur_req = "R3 integer";
        frame(60, 40, 8'h55, 0);
        check("R3 integer div", div_o, 5);
        check("R3 integer frac", frac_o, 0);

        cur_req = "R3 fraction";
        frame(70, 45, 8'h55, 0);
        check("R3 fraction div", div_o, 5);
        check("R3 fraction frac", frac_o, 5);

        cur_req = "R2 short break";
        frame(64, 56, 8'h55, 0);
        check("R2 short break div", div_o, 5);
        check("R2 short break frac", frac_o, 5);
        cur_req = "R2 exact break";
        frame(65, 56, 8'h55, 0);
        check("R2 exact break div", div_o, 7);
        check("R2 exact break frac", frac_o, 0);

        cur_req = "R6 byte 57";
        frame(100, 48, 8'h57, 0);
        check("R6 byte 57 err", err_o, 1);
        check("R6 byte 57 div", div_o, 7);
        cur_req = "R8 masked";
        check("R8 masked irq", irq_o, 0);
        mask = 1'b1;
        step(1'b1, 1'b1);
        check("R8 enabled irq", irq_o, 1);
        cur_req = "R7 sticky";
        frame(100, 48, 8'h55, 0);
        check("R7 sticky err after good sync", err_o, 1);
        check("R7 good sync div", div_o, 6);
        pulse_clr();
        check("R7 cleared", err_o, 0);
        check("R8 irq drops", irq_o, 0);

        cur_req = "R6 byte D5";
        frame(100, 64, 8'hD5, 0);
        check("R6 byte D5 err", err_o, 1);
        check("R6 byte D5 div", div_o, 6);
        pulse_clr();
        cur_req = "R6 byte 54";
        frame(100, 64, 8'h54, 0);
        check("R6 byte 54 err", err_o, 1);
        check("R6 byte 54 div", div_o, 6);
        pulse_clr();
        mask = 1'b0;

        cur_req = "R5 slave off";
        slv = 1'b0;
        frame(100, 72, 8'h55, 0);
        check("R5 slave off div", div_o, 6);
        slv = 1'b1;
        step(1'b1, 1'b1);

        cur_req = "R4 gated ticks";
        frame(100, 64, 8'h55, 1);
        check("R4 gated div", div_o, 8);
        check("R4 gated frac", frac_o, 0);

        cur_req = "R9 overflow";
        check("R9 narrow div before", s_div, 8);
        send(1'b0, 120, 0);
        send(1'b1, 5, 0);
        send(1'b0, 2060, 0);
        send(1'b1, 20, 0);
        frame(0, 48, 8'h55, 0);
        check("R9 narrow div kept", s_div, 8);
        check("R9 narrow no err", s_err, 0);
        pulse_clr();
        frame(120, 48, 8'h55, 0);
        check("R9 narrow resync div", s_div, 6);
        check("R9 narrow resync frac", s_frac, 0);

        cur_req = "R3 worked";
        frame(90, 12653, 8'h55, 0);
        check("R3 worked div", div_o, 16'h062D);
        check("R3 worked frac", frac_o, 5);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end
endmodule